// File: doc/BRIEF.md
# Packed Lane Move Merge Unit

This block computes the result of the move instructions that work on a 128-bit vector register holding four 32-bit single-precision lanes. Lane 0 occupies bits 31:0 and lane 3 bits 127:96. Each operation takes the current destination value and a source value, which is either another register or data returned from memory. It then produces a merged register value in which only the selected 32-bit or 64-bit portions are replaced. A separate operation collects the sign bit of each source lane into a small mask for a general-purpose register.

A request is presented with `in_valid` high. The merged value, the zero-extended sign mask and an alignment-fault flag appear registered one clock later with `out_valid`. The full-width aligned load checks that its memory address sits on a 16-byte boundary. When it does not, the unit raises the fault and returns the destination unchanged. Memory operands of half-width loads arrive in source bits 63:0, and those of scalar loads in source bits 31:0.

Top module: `lane_move_merge`

## Requirements
- R1: While `rst_n` is low, at the next rising edge `res_val`, `gpr_val`, `align_fault` and `out_valid` all become zero.
- R2: Op code 0 (aligned full load) with `mem_addr[3:0]` equal to zero yields `res_val` = source and `align_fault` = 0.
- R3: Op code 0 with any of `mem_addr[3:0]` set yields `align_fault` = 1 and `res_val` equal to the destination value, left unmodified.
- R4: Op code 1 (unaligned full load) yields `res_val` = source for every address and never raises `align_fault`.
- R5: Op code 2 (scalar load from memory) yields source bits 31:0 in result bits 31:0 and zeros in bits 127:32.
- R6: Op code 3 (scalar register move) yields source bits 31:0 in result bits 31:0 and keeps destination bits 127:32.
- R7: Op code 4 (low-half load) places source bits 63:0 in result bits 63:0 and keeps destination bits 127:64.
- R8: Op code 5 (high-half load) places source bits 63:0 in result bits 127:64 and keeps destination bits 63:0.
- R9: Op code 6 (low-to-high move) copies source bits 63:0 into result bits 127:64 and keeps destination bits 63:0.
- R10: Op code 7 (high-to-low move) copies source bits 127:64 into result bits 63:0 and keeps destination bits 127:64.
- R11: Op code 8 (sign gather) sets `gpr_val` bit i to source bit 32*i+31 for lanes 0 to 3, with bits 31:4 zero, and returns the destination unchanged. Every other op code drives `gpr_val` to zero.
- R12: Op codes 9 to 15 return the destination unchanged with `align_fault` = 0.
- R13: Each accepted request gives `out_valid` = 1 exactly one cycle later. A cycle with `in_valid` low gives `out_valid` = 0 in the next cycle and leaves `res_val`, `gpr_val` and `align_fault` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Request present this cycle |
| op_sel | input | 4 | Operation code |
| mem_addr | input | 32 | Byte address of the memory operand |
| dst_val | input | 128 | Current destination register value |
| src_val | input | 128 | Source register value or memory data |
| out_valid | output | 1 | Registered result valid |
| res_val | output | 128 | Merged destination value |
| gpr_val | output | 32 | Zero-extended sign mask for a general-purpose register |
| align_fault | output | 1 | Alignment fault from the aligned full load |

## Verification
The hardest case to reach is a misaligned aligned-load that arrives right after other traffic. Two things must hold there: the fault has to suppress the update, and the result has to equal the old destination rather than the source. Uniform random addresses would rarely be aligned, so the stimulus draws an aligned address half the time and a random one otherwise. Directed cases cover each single low address bit set, and an address offset that is a multiple of 16 but not of 32. Long idle gaps are mixed in so that holding the outputs is exercised against results of every op code.

// File: rtl/lmm_pkg.sv
`timescale 1ns/1ps
package lmm_pkg;
   localparam int OP_W = 4;
   typedef enum logic [OP_W-1:0] {
      OP_FULL_ALN = 4'd0,
      OP_FULL_UNA = 4'd1,
      OP_SCL_MEM  = 4'd2,
      OP_SCL_REG  = 4'd3,
      OP_LD_LO    = 4'd4,
      OP_LD_HI    = 4'd5,
      OP_LO2HI    = 4'd6,
      OP_HI2LO    = 4'd7,
      OP_SGNMSK   = 4'd8
   } lmm_op_e;
endpackage

// File: rtl/lmm_merge.sv
`timescale 1ns/1ps
module lmm_merge
   import lmm_pkg::*;
#(
   parameter int LANE_W = 32,
   parameter int LANES  = 4
) (
   input  logic [OP_W-1:0]          op,
   input  logic [LANE_W*LANES-1:0]  dst,
   input  logic [LANE_W*LANES-1:0]  src,
   output logic [LANE_W*LANES-1:0]  merged
);
   localparam int DW = LANE_W * LANES;
   localparam int HW = DW / 2;

   always_comb begin
      merged = dst;
      case (lmm_op_e'(op))
         OP_FULL_ALN, OP_FULL_UNA: merged = src;
         OP_SCL_MEM: merged = {{(DW-LANE_W){1'b0}}, src[LANE_W-1:0]};
         OP_SCL_REG: merged = {dst[DW-1:LANE_W], src[LANE_W-1:0]};
         OP_LD_LO:   merged = {dst[DW-1:HW], src[HW-1:0]};
         OP_LD_HI, OP_LO2HI: merged = {src[HW-1:0], dst[HW-1:0]};
         OP_HI2LO:   merged = {dst[DW-1:HW], src[DW-1:HW]};
         default:    merged = dst;
      endcase
   end
endmodule

// File: rtl/lmm_sign_gather.sv
`timescale 1ns/1ps
module lmm_sign_gather #(
   parameter int LANE_W = 32,
   parameter int LANES  = 4
) (
   input  logic [LANE_W*LANES-1:0] vec,
   output logic [LANES-1:0]        signs
);
   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign signs[g] = vec[g*LANE_W + LANE_W - 1];
   end
endmodule

// File: rtl/lmm_align_check.sv
`timescale 1ns/1ps
module lmm_align_check #(
   parameter int ADDR_W      = 32,
   parameter int ALIGN_BYTES = 16
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              check_en,
   output logic              misaligned
);
   localparam int ALIGN_LSB = $clog2(ALIGN_BYTES);

   if (ALIGN_LSB == 0) begin : g_no_check
      assign misaligned = 1'b0;
   end else begin : g_check
      assign misaligned = check_en && (|addr[ALIGN_LSB-1:0]);
   end
endmodule

// File: rtl/lane_move_merge.sv
`timescale 1ns/1ps
module lane_move_merge
   import lmm_pkg::*;
#(
   parameter int LANE_W      = 32,
   parameter int LANES       = 4,
   parameter int ADDR_W      = 32,
   parameter int GPR_W       = 32,
   parameter int ALIGN_BYTES = 16
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     in_valid,
   input  logic [3:0]               op_sel,
   input  logic [ADDR_W-1:0]        mem_addr,
   input  logic [LANE_W*LANES-1:0]  dst_val,
   input  logic [LANE_W*LANES-1:0]  src_val,
   output logic                     out_valid,
   output logic [LANE_W*LANES-1:0]  res_val,
   output logic [GPR_W-1:0]         gpr_val,
   output logic                     align_fault
);
   localparam int DW = LANE_W * LANES;

   if (LANES % 2 != 0) begin : g_bad_lanes
      $error("lane_move_merge: LANES must be even");
   end
   if (GPR_W < LANES) begin : g_bad_gpr
      $error("lane_move_merge: GPR_W must hold one bit per lane");
   end
   if ((ALIGN_BYTES & (ALIGN_BYTES - 1)) != 0) begin : g_bad_align
      $error("lane_move_merge: ALIGN_BYTES must be a power of two");
   end

   logic [DW-1:0]    merged;
   logic [LANES-1:0] signs;
   logic             misaligned;
   logic             is_mask_op;
   logic [DW-1:0]    res_d;
   logic [GPR_W-1:0] gpr_d;

   lmm_merge #(.LANE_W(LANE_W), .LANES(LANES)) u_merge (
      .op     (op_sel),
      .dst    (dst_val),
      .src    (src_val),
      .merged (merged)
   );

   lmm_sign_gather #(.LANE_W(LANE_W), .LANES(LANES)) u_gather (
      .vec   (src_val),
      .signs (signs)
   );

   lmm_align_check #(.ADDR_W(ADDR_W), .ALIGN_BYTES(ALIGN_BYTES)) u_align (
      .addr       (mem_addr),
      .check_en   (op_sel == OP_FULL_ALN),
      .misaligned (misaligned)
   );

   assign is_mask_op = (op_sel == OP_SGNMSK);
   assign res_d      = misaligned ? dst_val : merged;
   assign gpr_d      = is_mask_op ? {{(GPR_W-LANES){1'b0}}, signs} : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid   <= 1'b0;
         res_val     <= '0;
         gpr_val     <= '0;
         align_fault <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            res_val     <= res_d;
            gpr_val     <= gpr_d;
            align_fault <= misaligned;
         end
      end
   end
endmodule

// File: rtl/lmm_chk.sv
`timescale 1ns/1ps
module lmm_chk #(
   parameter int DW     = 128,
   parameter int ADDR_W = 32,
   parameter int GPR_W  = 32,
   parameter int LANES  = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic [3:0]        op_sel,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [DW-1:0]     dst_val,
   input logic [DW-1:0]     src_val,
   input logic              out_valid,
   input logic [DW-1:0]     res_val,
   input logic [GPR_W-1:0]  gpr_val,
   input logic              align_fault
);
   localparam int HW = DW / 2;

   // R3
   misaligned_keeps_dst_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op_sel == 4'd0 && mem_addr[3:0] != 4'd0)
      |=> (align_fault && res_val == $past(dst_val)));

   // R4
   unaligned_no_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op_sel == 4'd1) |=> (!align_fault && res_val == $past(src_val)));

   // R9
   lo_to_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op_sel == 4'd6)
      |=> (res_val[DW-1:HW] == $past(src_val[HW-1:0]) && res_val[HW-1:0] == $past(dst_val[HW-1:0])));

   // R10
   hi_to_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op_sel == 4'd7)
      |=> (res_val[HW-1:0] == $past(src_val[DW-1:HW]) && res_val[DW-1:HW] == $past(dst_val[DW-1:HW])));

   // R11
   gpr_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (gpr_val[GPR_W-1:LANES] == '0));

   // R13
   valid_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   // R13
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!out_valid && $stable(res_val) && $stable(gpr_val) && $stable(align_fault)));
endmodule

bind lane_move_merge lmm_chk #(
   .DW(LANE_W*LANES), .ADDR_W(ADDR_W), .GPR_W(GPR_W), .LANES(LANES)
) u_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
   .mem_addr(mem_addr), .dst_val(dst_val), .src_val(src_val),
   .out_valid(out_valid), .res_val(res_val), .gpr_val(gpr_val),
   .align_fault(align_fault)
);

// File: tb/lane_move_merge_tb.sv
`timescale 1ns/1ps
module lane_move_merge_tb;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_valid = 1'b0;
   logic [3:0]   op_sel = '0;
   logic [31:0]  mem_addr = '0;
   logic [127:0] dst_val = '0;
   logic [127:0] src_val = '0;
   logic         out_valid;
   logic [127:0] res_val;
   logic [31:0]  gpr_val;
   logic         align_fault;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   lane_move_merge u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
      .mem_addr(mem_addr), .dst_val(dst_val), .src_val(src_val),
      .out_valid(out_valid), .res_val(res_val), .gpr_val(gpr_val),
      .align_fault(align_fault)
   );

   function automatic logic exp_fault(input logic [3:0] op, input logic [31:0] a);
      return (op == 4'd0) && (a[3:0] != 4'd0);
   endfunction

   function automatic logic [127:0] exp_res(input logic [3:0] op, input logic [127:0] d,
                                            input logic [127:0] s, input logic [31:0] a);
      case (op)
         4'd0: return exp_fault(op, a) ? d : s;
         4'd1: return s;
         4'd2: return {96'd0, s[31:0]};
         4'd3: return {d[127:32], s[31:0]};
         4'd4: return {d[127:64], s[63:0]};
         4'd5: return {s[63:0], d[63:0]};
         4'd6: return {s[63:0], d[63:0]};
         4'd7: return {d[127:64], s[127:64]};
         default: return d;
      endcase
   endfunction

   function automatic logic [31:0] exp_gpr(input logic [3:0] op, input logic [127:0] s);
      if (op != 4'd8) return 32'd0;
      return {28'd0, s[127], s[95], s[63], s[31]};
   endfunction

   function automatic string req_of(input logic [3:0] op, input logic [31:0] a);
      case (op)
         4'd0: return (a[3:0] != 0) ? "R3" : "R2";
         4'd1: return "R4";
         4'd2: return "R5";
         4'd3: return "R6";
         4'd4: return "R7";
         4'd5: return "R8";
         4'd6: return "R9";
         4'd7: return "R10";
         4'd8: return "R11";
         default: return "R12";
      endcase
   endfunction

   task automatic cmp(input string req, input string what, input logic [127:0] act,
                      input logic [127:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic run_op(input logic [3:0] op, input logic [127:0] d,
                         input logic [127:0] s, input logic [31:0] a);
      string req;
      req = req_of(op, a);
      @(negedge clk);
      in_valid = 1'b1; op_sel = op; dst_val = d; src_val = s; mem_addr = a;
      @(posedge clk);
      @(negedge clk);
      in_valid = 1'b0;
      cmp("R13", "out_valid", {127'd0, out_valid}, 128'd1);
      cmp(req, "res_val", res_val, exp_res(op, d, s, a));
      cmp(op == 4'd8 ? "R11" : req, "gpr_val", {96'd0, gpr_val}, {96'd0, exp_gpr(op, s)});
      cmp(op == 4'd1 ? "R4" : req, "align_fault", {127'd0, align_fault},
          {127'd0, exp_fault(op, a)});
   endtask

   task automatic idle_check();
      logic [127:0] r;
      logic [31:0]  g;
      logic         f;
      r = res_val; g = gpr_val; f = align_fault;
      op_sel = 4'd1; src_val = ~res_val; dst_val = ~res_val; mem_addr = 32'h7;
      @(posedge clk);
      @(negedge clk);
      cmp("R13", "idle out_valid", {127'd0, out_valid}, 128'd0);
      cmp("R13", "idle res_val", res_val, r);
      cmp("R13", "idle gpr_val", {96'd0, gpr_val}, {96'd0, g});
      cmp("R13", "idle align_fault", {127'd0, align_fault}, {127'd0, f});
   endtask

   function automatic logic [127:0] rnd128();
      return {$urandom, $urandom, $urandom, $urandom};
   endfunction

   initial begin
      #(20ns * 200000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [127:0] d0, s0;
      void'($urandom(32'h5EED_0042));
      d0 = 128'hA5A5A5A5_5A5A5A5A_0F0F0F0F_F0F0F0F0;
      s0 = 128'h80000000_7FFFFFFF_FFFFFFFF_00000001;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1: outputs cleared in reset
      cmp("R1", "out_valid", {127'd0, out_valid}, 128'd0);
      cmp("R1", "res_val", res_val, 128'd0);
      cmp("R1", "gpr_val", {96'd0, gpr_val}, 128'd0);
      cmp("R1", "align_fault", {127'd0, align_fault}, 128'd0);
      rst_n = 1'b1;

      // Directed corners
      run_op(4'd0, d0, s0, 32'h0000_1000);   // R2
      run_op(4'd0, d0, s0, 32'h0000_1010);   // R2 multiple of 16 not 32
      for (int b = 0; b < 4; b++) run_op(4'd0, d0, s0, 32'h100 | (32'd1 << b)); // R3
      run_op(4'd1, d0, s0, 32'h0000_0003);   // R4
      run_op(4'd2, d0, s0, 32'h4);           // R5
      run_op(4'd3, d0, s0, 32'h0);           // R6
      run_op(4'd4, d0, s0, 32'h8);           // R7
      run_op(4'd5, d0, s0, 32'h8);           // R8
      run_op(4'd6, d0, s0, 32'h0);           // R9
      run_op(4'd7, d0, s0, 32'h0);           // R10
      run_op(4'd8, d0, s0, 32'h0);           // R11 mask 1010b
      run_op(4'd8, d0, ~s0, 32'h0);          // R11 mask 0101b
      for (int c = 9; c < 16; c++) run_op(4'(c), d0, s0, 32'h3); // R12
      run_op(4'd0, d0, s0, 32'h5);
      idle_check();                           // R13 after a fault
      run_op(4'd8, d0, s0, 32'h0);
      idle_check();                           // R13 after a mask

      // Constrained random
      for (int i = 0; i < 400; i++) begin
         logic [31:0] a;
         logic [3:0]  op;
         a  = $urandom;
         if ($urandom_range(1, 0) == 0) a[3:0] = 4'd0;
         op = ($urandom_range(9, 0) == 0) ? 4'($urandom_range(15, 9)) : 4'($urandom_range(8, 0));
         run_op(op, rnd128(), rnd128(), a);
         if ($urandom_range(4, 0) == 0) idle_check();
      end

      // R1: reset again after traffic
      @(negedge clk);
      rst_n = 1'b0;
      @(posedge clk);
      @(negedge clk);
      cmp("R1", "res_val after reset", res_val, 128'd0);
      cmp("R1", "out_valid after reset", {127'd0, out_valid}, 128'd0);

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule